// File: doc/BRIEF.md
# Single-Bit Sector Code Checker

This block handles the check side of a single-error-correcting code kept beside each 512-byte flash sector. It takes the raw 32-bit parity word that a parity engine produced while the sector streamed past. From it the block forms the 24-bit code that is written to the spare area. It compares that code against the three bytes read back from the spare area and sorts the difference into one of four classes. The classes are: no error, one data bit to flip, damage confined to the stored code, and beyond repair.

Software or a sequencer presents the raw word and the stored bytes and pulses `start`. One cycle later the block presents the packed code bytes, the class, and for a repairable error the byte offset and a one-hot mask. The caller XORs that mask into the sector buffer. The block never writes the buffer. It does not compute parity over the data.

Top module: `nand_ecc1_check`

## Requirements
- R1: The 24-bit code is formed from the raw word by keeping raw bits 11:0 as code bits 11:0 and raw bits 27:16 as code bits 23:12. Raw bits 31:28 and 15:12 have no effect on any output.
- R2: The formed code is bit-inverted, so a raw word of zero yields the code 0xFFFFFF, and stored bytes of 0xFF then check clean.
- R3: The code leaves the block least significant byte first: `code_b0` carries code bits 7:0, `code_b1` bits 15:8 and `code_b2` bits 23:16. `stored_b0..b2` use the same order.
- R4: The syndrome is the stored code XOR the formed code. A zero syndrome gives `status` 0 (clean).
- R5: When syndrome bits 23:12 XOR syndrome bits 11:0 equal 0xFFF and the byte offset is in range, `status` is 1 (repair). `err_byte` is syndrome bits 23:15, and `err_mask` has only bit number syndrome[14:12] set.
- R6: `err_mask` and `err_byte` are zero whenever `status` is not 1.
- R7: A syndrome with exactly one bit set gives `status` 2 (code only), and no data repair is indicated.
- R8: Any other nonzero syndrome gives `status` 3 (beyond repair).
- R9: A repair candidate whose byte offset is not below the parameter `SECTOR_BYTES` gives `status` 3.
- R10: Results and code bytes are registered on the clock edge that samples `start`. `done` is high for exactly the following cycle per start, and all outputs hold their values until the next start. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample inputs and evaluate |
| raw_parity | input | 32 | Raw parity word from the parity engine |
| stored_b0 | input | 8 | Stored code, bits 7:0 |
| stored_b1 | input | 8 | Stored code, bits 15:8 |
| stored_b2 | input | 8 | Stored code, bits 23:16 |
| code_b0 | output | 8 | Formed code, bits 7:0 |
| code_b1 | output | 8 | Formed code, bits 15:8 |
| code_b2 | output | 8 | Formed code, bits 23:16 |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 clean, 1 repair, 2 code only, 3 beyond repair |
| err_byte | output | 9 | Byte offset to repair |
| err_mask | output | 8 | One-hot bit to flip in that byte |

## Verification
The bench builds each stored code by XORing a chosen syndrome into the code expected from the raw word. The class under test is therefore fixed by construction. Repair syndromes at the first byte, the last byte and a middle byte, with bit positions 0, 7 and 3, check the locator split between offset and bit. Single-bit syndromes at both ends and at the half boundary separate code-only damage from repair. Two-bit and all-ones syndromes separate both from beyond-repair. A second instance with a shorter sector shows the range limit turning an otherwise valid repair into beyond-repair. Raw words differing only in reserved bits, and input changes without `start`, show which inputs can move the outputs.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;

    localparam int RAW_W     = 32;
    localparam int HALF_W    = 12;
    localparam int CODE_W    = 2 * HALF_W;
    localparam int BIT_W     = 3;
    localparam int MASK_W    = 1 << BIT_W;
    localparam int LOC_W     = HALF_W - BIT_W;
    localparam int CODE_BYTES = CODE_W / 8;
    localparam int LO_BASE   = 0;
    localparam int HI_BASE   = 16;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_UNCORR    = 2'd3
    } chk_status_e;

    typedef struct packed {
        chk_status_e         status;
        logic [LOC_W-1:0]    byte_idx;
        logic [MASK_W-1:0]   mask;
    } chk_result_t;

    // Exactly one bit set in a code-sized vector.
    function automatic logic single_bit(input logic [CODE_W-1:0] v);
        return (v != '0) && ((v & (v - CODE_W'(1))) == '0);
    endfunction

endpackage

// File: rtl/nand_ecc1_packer.sv
module nand_ecc1_packer
    import nand_ecc1_pkg::*;
(
    input  logic [RAW_W-1:0]  raw,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] squeezed;
    logic              unused_reserved;

    // Two halves of the raw word, each with its reserved nibble dropped.
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int SRC = (h == 0) ? LO_BASE : HI_BASE;
        assign squeezed[h*HALF_W +: HALF_W] = raw[SRC +: HALF_W];
    end

    assign unused_reserved = ^{raw[RAW_W-1:HI_BASE+HALF_W], raw[HI_BASE-1:HALF_W]};

    // Inversion lets an erased spare area match an erased sector.
    assign code = ~squeezed;
endmodule

// File: rtl/nand_ecc1_classifier.sv
module nand_ecc1_classifier
    import nand_ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [CODE_W-1:0] syndrome,
    output chk_result_t       result
);
    logic [HALF_W-1:0] upper;
    logic [HALF_W-1:0] lower;
    logic              pattern_ok;
    logic [LOC_W-1:0]  loc_byte;
    logic [BIT_W-1:0]  loc_bit;
    logic              in_range;

    assign upper      = syndrome[CODE_W-1:HALF_W];
    assign lower      = syndrome[HALF_W-1:0];
    assign pattern_ok = ((upper ^ lower) == {HALF_W{1'b1}});
    assign loc_byte   = upper[HALF_W-1:BIT_W];
    assign loc_bit    = upper[BIT_W-1:0];
    assign in_range   = (32'(loc_byte) < 32'(SECTOR_BYTES));

    always_comb begin
        result = '{status: ST_UNCORR, byte_idx: '0, mask: '0};
        if (syndrome == '0) begin
            result.status = ST_CLEAN;
        end else if (pattern_ok) begin
            if (in_range) begin
                result.status   = ST_FIXED;
                result.byte_idx = loc_byte;
                result.mask     = MASK_W'(1) << loc_bit;
            end
        end else if (single_bit(syndrome)) begin
            result.status = ST_CODE_ONLY;
        end
    end

    always_comb begin
        if (result.status == ST_FIXED)
            a_fixed_pattern_r5: assert ((upper ^ lower) == {HALF_W{1'b1}});
        if (result.status == ST_CODE_ONLY)
            a_code_only_single_r7: assert ($countones(syndrome) == 1);
    end
endmodule

// File: rtl/nand_ecc1_result_reg.sv
module nand_ecc1_result_reg
    import nand_ecc1_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  chk_result_t       res_in,
    output logic [CODE_W-1:0] code_q,
    output chk_result_t       res_q,
    output logic              done_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            res_q  <= '{status: ST_CLEAN, byte_idx: '0, mask: '0};
            done_q <= 1'b0;
        end else begin
            done_q <= load;
            if (load) begin
                code_q <= code_in;
                res_q  <= res_in;
            end
        end
    end

    p_done_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> done_q);
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(res_q) && $stable(code_q) && !done_q));
endmodule

// File: rtl/nand_ecc1_check.sv
module nand_ecc1_check
    import nand_ecc1_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] raw_parity,
    input  logic [7:0]  stored_b0,
    input  logic [7:0]  stored_b1,
    input  logic [7:0]  stored_b2,
    output logic [7:0]  code_b0,
    output logic [7:0]  code_b1,
    output logic [7:0]  code_b2,
    output logic        done,
    output logic [1:0]  status,
    output logic [8:0]  err_byte,
    output logic [7:0]  err_mask
);
    logic [CODE_W-1:0] calc_code;
    logic [CODE_W-1:0] stored_code;
    logic [CODE_W-1:0] syndrome;
    logic [CODE_W-1:0] code_q;
    chk_result_t       res_c;
    chk_result_t       res_q;

    // Spare-area bytes arrive least significant first.
    assign stored_code = {stored_b2, stored_b1, stored_b0};

    nand_ecc1_packer u_packer (
        .raw  (raw_parity),
        .code (calc_code)
    );

    assign syndrome = stored_code ^ calc_code;

    nand_ecc1_classifier #(.SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .syndrome (syndrome),
        .result   (res_c)
    );

    nand_ecc1_result_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .code_in (calc_code),
        .res_in  (res_c),
        .code_q  (code_q),
        .res_q   (res_q),
        .done_q  (done)
    );

    assign code_b0  = code_q[7:0];
    assign code_b1  = code_q[15:8];
    assign code_b2  = code_q[23:16];
    assign status   = res_q.status;
    assign err_byte = res_q.byte_idx;
    assign err_mask = res_q.mask;

    p_mask_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1) |-> ($countones(err_mask) == 1));
    p_no_locator_r6: assert property (@(posedge clk) disable iff (rst)
        (status != 2'd1) |-> (err_mask == '0 && err_byte == '0));
    p_range_r9: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd1) |-> (32'(err_byte) < 32'(SECTOR_BYTES)));
    p_clean_match_r4: assert property (@(posedge clk) disable iff (rst)
        (start && stored_code == calc_code) |=> (status == 2'd0));
endmodule

// File: tb/nand_ecc1_check_tb.sv
module nand_ecc1_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SMALL_SECTOR = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] raw_parity = '0;
    logic [7:0]  sb0 = '0, sb1 = '0, sb2 = '0;
    logic [7:0]  cb0, cb1, cb2, scb0, scb1, scb2;
    logic        done, s_done;
    logic [1:0]  status, s_status;
    logic [8:0]  err_byte, s_err_byte;
    logic [7:0]  err_mask, s_err_mask;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc1_check u_dut (
        .clk(clk), .rst(rst), .start(start), .raw_parity(raw_parity),
        .stored_b0(sb0), .stored_b1(sb1), .stored_b2(sb2),
        .code_b0(cb0), .code_b1(cb1), .code_b2(cb2),
        .done(done), .status(status), .err_byte(err_byte), .err_mask(err_mask)
    );

    nand_ecc1_check #(.SECTOR_BYTES(SMALL_SECTOR)) u_dut_small (
        .clk(clk), .rst(rst), .start(start), .raw_parity(raw_parity),
        .stored_b0(sb0), .stored_b1(sb1), .stored_b2(sb2),
        .code_b0(scb0), .code_b1(scb1), .code_b2(scb2),
        .done(s_done), .status(s_status), .err_byte(s_err_byte), .err_mask(s_err_mask)
    );

    function automatic logic [23:0] model_code(input logic [31:0] raw);
        return ~{raw[27:16], raw[11:0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Present raw word and stored = expected code ^ syn, pulse start, stop after the result edge.
    task automatic run_case(input logic [31:0] raw, input logic [23:0] syn);
        logic [23:0] st;
        st = model_code(raw) ^ syn;
        @(negedge clk);
        raw_parity = raw;
        {sb2, sb1, sb0} = st;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic [1:0] st,
                              input logic [8:0] b, input logic [7:0] m);
        chk(req, "done", {31'd0, done}, 32'd1);
        chk(req, "status", {30'd0, status}, {30'd0, st});
        chk(req, "err_byte", {23'd0, err_byte}, {23'd0, b});
        chk(req, "err_mask", {24'd0, err_mask}, {24'd0, m});
    endtask

    function automatic logic [23:0] fix_syn(input logic [8:0] b, input logic [2:0] k);
        logic [11:0] up;
        up = {b, k};
        return {up, ~up};
    endfunction

    task automatic t_reset();
        chk("R10", "reset done", {31'd0, done}, 32'd0);
        chk("R10", "reset status", {30'd0, status}, 32'd0);
        chk("R10", "reset code", {8'd0, cb2, cb1, cb0}, 32'd0);
        chk("R10", "reset mask", {24'd0, err_mask}, 32'd0);
    endtask

    task automatic t_pack();
        run_case(32'h0123_4567, 24'd0);
        chk("R1", "packed code", {8'd0, cb2, cb1, cb0}, 32'h00ED_CA98);
        chk("R3", "code_b0", {24'd0, cb0}, 32'h98);
        chk("R3", "code_b2", {24'd0, cb2}, 32'hED);
        expect_res("R4", 2'd0, 9'd0, 8'd0);
        run_case(32'hF123_F567, 24'd0);
        chk("R1", "reserved bits ignored", {8'd0, cb2, cb1, cb0}, 32'h00ED_CA98);
        chk("R1", "reserved bits status", {30'd0, status}, 32'd0);
    endtask

    task automatic t_erased();
        @(negedge clk);
        raw_parity = 32'd0;
        {sb2, sb1, sb0} = 24'hFF_FFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "erased code", {8'd0, cb2, cb1, cb0}, 32'h00FF_FFFF);
        chk("R2", "erased status", {30'd0, status}, 32'd0);
    endtask

    task automatic t_fixed(input logic [8:0] b, input logic [2:0] k);
        run_case(32'h0A5C_03C1, fix_syn(b, k));
        expect_res("R5", 2'd1, b, 8'd1 << k);
    endtask

    task automatic t_code_only(input int n);
        run_case(32'h0BEE_0F00, 24'd1 << n);
        expect_res("R7", 2'd2, 9'd0, 8'd0);
        chk("R6", "code-only mask", {24'd0, err_mask}, 32'd0);
    endtask

    task automatic t_uncorr(input logic [23:0] syn);
        run_case(32'h0777_0333, syn);
        expect_res("R8", 2'd3, 9'd0, 8'd0);
    endtask

    task automatic t_range();
        run_case(32'h0123_0456, fix_syn(9'd299, 3'd2));
        chk("R9", "small in range", {30'd0, s_status}, 32'd1);
        chk("R9", "small in range byte", {23'd0, s_err_byte}, 32'd299);
        run_case(32'h0123_0456, fix_syn(9'd300, 3'd2));
        chk("R9", "small at limit", {30'd0, s_status}, 32'd3);
        chk("R9", "small at limit mask", {24'd0, s_err_mask}, 32'd0);
        chk("R9", "full sector accepts", {30'd0, status}, 32'd1);
        run_case(32'h0123_0456, fix_syn(9'd400, 3'd6));
        chk("R9", "small beyond", {30'd0, s_status}, 32'd3);
        chk("R9", "full sector byte", {23'd0, err_byte}, 32'd400);
    endtask

    task automatic t_hold();
        run_case(32'h0A5C_03C1, fix_syn(9'd17, 3'd5));
        @(negedge clk);
        chk("R10", "done one cycle", {31'd0, done}, 32'd0);
        raw_parity = 32'hFFFF_FFFF;
        {sb2, sb1, sb0} = 24'h12_3456;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "hold status", {30'd0, status}, 32'd1);
        chk("R10", "hold byte", {23'd0, err_byte}, 32'd17);
        chk("R10", "hold code", {8'd0, cb2, cb1, cb0}, {8'd0, model_code(32'h0A5C_03C1)});
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_pack();
        t_erased();
        t_fixed(9'd0, 3'd0);
        t_fixed(9'd511, 3'd7);
        t_fixed(9'h05A, 3'd3);
        t_code_only(0);
        t_code_only(12);
        t_code_only(23);
        t_uncorr(24'h00_0003);
        t_uncorr(24'hFF_FFFF);
        t_uncorr(24'h80_0001);
        t_range();
        t_hold();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule